// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block tracks which architectural registers still await a result. It keeps one pending bit per register. When an instruction issues to a selected unit and intends to write, the bit for its destination rises. The bit drops when a granted register-file write to that register takes place. It also drops when the owning unit reports completion without valid result data, because no write will ever arrive for it.

Issue logic uses the check ports. Each source operand presents its register and an active flag. The block answers combinationally, from the stored vector, whether that register still has a write outstanding. A non-zero answer holds that read request back. Once the unit owning a source is busy and the source has seen no hazard, checking for that source stops until the unit goes idle. This keeps a later writer from stalling a read that has already passed. Register selects are binary indices or one-hot masks, chosen by a parameter. All write units share one set vector and one clear vector.

Top module: `wr_pending_board`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `pending` is all zero and no hazard is reported. An issue attempted during reset sets no bit.
- R2: A destination bit is set only on a rising clock edge where `iss_fire`, `iss_sel` and `iss_wflag` of that unit are all 1. If any of the three is 0, nothing is set.
- R3: A cycle with `wr_grant` high clears the bit of `wr_dest`. `pending` still shows the bit during that cycle and shows it cleared on the next cycle.
- R4: A unit captures its write flag and its destination on issue. If the unit later raises `unit_done` with `unit_dok` low while the captured flag is 1, the destination bit is cleared on the next edge. With `unit_dok` high, the done pulse clears nothing.
- R5: The captured write flag is reset in any cycle where `unit_busy` is low. A later done without data then clears nothing.
- R6: In binary mode (MODE=0), register n maps to mask bit n (mask = 1 << n). In one-hot mode (MODE=1), the select is used directly as the mask. Multi-bit one-hot check masks test every named bit.
- R7: `chk_hazard[s]` = `chk_act[s]` AND OR-reduce(`pending` AND mask of `chk_reg[s]`). It is 0 when the source is stopped (R8). `any_hazard` is the OR of all `chk_hazard` bits.
- R8: After a cycle where `chk_busy[s]` is 1 and `chk_hazard[s]` is 0, `chk_hazard[s]` stays 0 while `chk_busy[s]` remains 1. Checking resumes on the cycle after `chk_busy[s]` falls.
- R9: Set and clear requests from all units are OR-combined, so several units can set or clear different bits in the same cycle.
- R10: If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: A bit set on an edge is not seen by a check in the cycle of that issue. It is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_fire | input | NUNIT | Issue pulse for each unit |
| iss_sel | input | NUNIT | Unit is the one selected for the issuing instruction |
| iss_wflag | input | NUNIT | Instruction intends to write a register |
| iss_dest | input | NUNIT*SELW | Destination register select for each unit |
| wr_grant | input | NUNIT | Granted register-file write this cycle |
| wr_dest | input | NUNIT*SELW | Register written by each unit |
| unit_busy | input | NUNIT | Unit holds an instruction |
| unit_done | input | NUNIT | Unit finished its operation |
| unit_dok | input | NUNIT | Unit produced valid result data |
| chk_act | input | NSRC | Source operand read is active |
| chk_busy | input | NSRC | Unit owning the source is busy |
| chk_reg | input | NSRC*SELW | Source register select |
| chk_hazard | output | NSRC | Read-after-write hazard for each source |
| any_hazard | output | 1 | OR of all source hazards |
| pending | output | NREG | Stored pending-write vector |

## Verification
Set and clear effects on `pending` are due one edge after the stimulus cycle. `chk_hazard` is due in the stimulus cycle itself, computed from the vector stored before that edge. The stop state of a source takes effect one edge after the qualifying busy cycle.

The driver applies inputs just after a falling edge and queues the expected vector and hazards for that cycle. The expectation comes from a model that advances only at the following rising edge. The monitor pops and compares a quarter period after the same falling edge, so every comparison falls between the input change and the edge that consumes it.

// File: rtl/hzsb_pkg.sv
package hzsb_pkg;

    typedef enum logic {
        ADDR_BINARY = 1'b0,
        ADDR_ONEHOT = 1'b1
    } addr_mode_e;

    // width of a register select for the chosen addressing mode
    function automatic int sel_width(int nreg, addr_mode_e mode);
        if (mode == ADDR_ONEHOT)
            return nreg;
        return (nreg > 1) ? $clog2(nreg) : 1;
    endfunction

    // per-unit control bundle seen by the drop tracker
    typedef struct packed {
        logic fire;
        logic sel;
        logic wflag;
        logic busy;
        logic done;
        logic dok;
    } unit_ctl_t;

endpackage

// File: rtl/hzsb_regmask.sv
module hzsb_regmask
    import hzsb_pkg::*;
#(
    parameter int         NREG = 16,
    parameter addr_mode_e MODE = ADDR_BINARY,
    localparam int        SELW = sel_width(NREG, MODE)
) (
    input  logic [SELW-1:0] sel,
    output logic [NREG-1:0] mask
);

    generate
        if (MODE == ADDR_ONEHOT) begin : g_onehot
            assign mask = sel;
        end else begin : g_binary
            for (genvar i = 0; i < NREG; i++) begin : g_bit
                assign mask[i] = (sel == SELW'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/hzsb_drop_track.sv
module hzsb_drop_track
    import hzsb_pkg::*;
#(
    parameter int         NREG = 16,
    parameter addr_mode_e MODE = ADDR_BINARY,
    localparam int        SELW = sel_width(NREG, MODE)
) (
    input  logic            clk,
    input  logic            rst,
    input  unit_ctl_t       ctl,
    input  logic [SELW-1:0] dest,
    output logic [NREG-1:0] drop_mask
);

    logic            wflag_q;
    logic [SELW-1:0] dest_q;
    logic [NREG-1:0] dest_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            wflag_q <= 1'b0;
            dest_q  <= '0;
        end else begin
            if (!ctl.busy)
                wflag_q <= 1'b0;
            if (ctl.fire && ctl.sel) begin
                wflag_q <= ctl.wflag;
                dest_q  <= dest;
            end
        end
    end

    hzsb_regmask #(.NREG(NREG), .MODE(MODE)) u_dest_mask (
        .sel  (dest_q),
        .mask (dest_mask)
    );

    // finished without data: the promised write will never come
    assign drop_mask = (ctl.done && wflag_q && !ctl.dok) ? dest_mask : '0;

endmodule

// File: rtl/hzsb_src_check.sv
module hzsb_src_check #(
    parameter int NREG = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act,
    input  logic            busy,
    input  logic [NREG-1:0] mask,
    input  logic [NREG-1:0] pend,
    output logic            hazard
);

    logic stop_q;

    assign hazard = act && !stop_q && (|(pend & mask));

    always_ff @(posedge clk) begin
        if (rst)
            stop_q <= 1'b0;
        else
            stop_q <= busy && (stop_q || !hazard);
    end

endmodule

// File: rtl/wr_pending_board.sv
module wr_pending_board
    import hzsb_pkg::*;
#(
    parameter int         NREG  = 16,
    parameter addr_mode_e MODE  = ADDR_BINARY,
    parameter int         NUNIT = 2,
    parameter int         NSRC  = 2,
    localparam int        SELW  = sel_width(NREG, MODE)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUNIT-1:0]      iss_fire,
    input  logic [NUNIT-1:0]      iss_sel,
    input  logic [NUNIT-1:0]      iss_wflag,
    input  logic [NUNIT*SELW-1:0] iss_dest,
    input  logic [NUNIT-1:0]      wr_grant,
    input  logic [NUNIT*SELW-1:0] wr_dest,
    input  logic [NUNIT-1:0]      unit_busy,
    input  logic [NUNIT-1:0]      unit_done,
    input  logic [NUNIT-1:0]      unit_dok,
    input  logic [NSRC-1:0]       chk_act,
    input  logic [NSRC-1:0]       chk_busy,
    input  logic [NSRC*SELW-1:0]  chk_reg,
    output logic [NSRC-1:0]       chk_hazard,
    output logic                  any_hazard,
    output logic [NREG-1:0]       pending
);

    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] set_vec;
    logic [NREG-1:0] clr_vec;
    logic [NREG-1:0] set_part [NUNIT];
    logic [NREG-1:0] clr_part [NUNIT];

    generate
        for (genvar u = 0; u < NUNIT; u++) begin : g_unit
            unit_ctl_t       ctl;
            logic [NREG-1:0] iss_mask;
            logic [NREG-1:0] wr_mask;
            logic [NREG-1:0] drop_mask;

            assign ctl = '{fire:  iss_fire[u],  sel:  iss_sel[u],
                           wflag: iss_wflag[u], busy: unit_busy[u],
                           done:  unit_done[u], dok:  unit_dok[u]};

            hzsb_regmask #(.NREG(NREG), .MODE(MODE)) u_iss_mask (
                .sel  (iss_dest[u*SELW +: SELW]),
                .mask (iss_mask)
            );

            hzsb_regmask #(.NREG(NREG), .MODE(MODE)) u_wr_mask (
                .sel  (wr_dest[u*SELW +: SELW]),
                .mask (wr_mask)
            );

            hzsb_drop_track #(.NREG(NREG), .MODE(MODE)) u_drop (
                .clk       (clk),
                .rst       (rst),
                .ctl       (ctl),
                .dest      (iss_dest[u*SELW +: SELW]),
                .drop_mask (drop_mask)
            );

            assign set_part[u] = (ctl.fire && ctl.sel && ctl.wflag) ? iss_mask : '0;
            assign clr_part[u] = (wr_grant[u] ? wr_mask : '0) | drop_mask;
        end
    endgenerate

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int u = 0; u < NUNIT; u++) begin
            set_vec = set_vec | set_part[u];
            clr_vec = clr_vec | clr_part[u];
        end
    end

    // set is applied after clear so a fresh writer wins a collision
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            logic [NREG-1:0] rd_mask;

            hzsb_regmask #(.NREG(NREG), .MODE(MODE)) u_rd_mask (
                .sel  (chk_reg[s*SELW +: SELW]),
                .mask (rd_mask)
            );

            hzsb_src_check #(.NREG(NREG)) u_check (
                .clk    (clk),
                .rst    (rst),
                .act    (chk_act[s]),
                .busy   (chk_busy[s]),
                .mask   (rd_mask),
                .pend   (pend_q),
                .hazard (chk_hazard[s])
            );
        end
    endgenerate

    assign any_hazard = |chk_hazard;
    assign pending    = pend_q;

endmodule

// File: rtl/hzsb_checker.sv
module hzsb_checker #(
    parameter int NREG = 16,
    parameter int NSRC = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [NREG-1:0] set_vec,
    input logic [NREG-1:0] clr_vec,
    input logic [NREG-1:0] pend,
    input logic [NSRC-1:0] chk_act,
    input logic [NSRC-1:0] chk_busy,
    input logic [NSRC-1:0] chk_hazard
);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (pend == '0)); // R1

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R10

    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec & ~set_vec) != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0)); // R3

    AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((pend ^ $past(pend)) & ~$past(set_vec | clr_vec)) == '0)); // R9

    AST_HAZARD_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
        ((chk_hazard & ~chk_act) == '0)); // R7

    AST_HAZARD_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (chk_hazard != '0) |-> (pend != '0)); // R7

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_stop
            AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (chk_busy[s] && !chk_hazard[s]) |=> (!chk_busy[s] || !chk_hazard[s])); // R8
        end
    endgenerate

endmodule

bind wr_pending_board hzsb_checker #(.NREG(NREG), .NSRC(NSRC)) u_hzsb_chk (
    .clk        (clk),
    .rst        (rst),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .pend       (pending),
    .chk_act    (chk_act),
    .chk_busy   (chk_busy),
    .chk_hazard (chk_hazard)
);

// File: tb/tb_wr_pending_board.sv
module tb_wr_pending_board;
    import hzsb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // binary-mode instance: 16 registers, 2 units, 2 sources
    logic [1:0] fire, sel, wflag, grant, busy, done, dok, act, cbusy;
    logic [3:0] idest0, idest1, wdest0, wdest1, creg0, creg1;
    logic [1:0]  haz;
    logic        anyh;
    logic [15:0] pend;

    wr_pending_board #(.NREG(16), .MODE(ADDR_BINARY), .NUNIT(2), .NSRC(2)) dut (
        .clk(clk), .rst(rst),
        .iss_fire(fire), .iss_sel(sel), .iss_wflag(wflag),
        .iss_dest({idest1, idest0}),
        .wr_grant(grant), .wr_dest({wdest1, wdest0}),
        .unit_busy(busy), .unit_done(done), .unit_dok(dok),
        .chk_act(act), .chk_busy(cbusy), .chk_reg({creg1, creg0}),
        .chk_hazard(haz), .any_hazard(anyh), .pending(pend)
    );

    // one-hot instance: 8 registers, 1 unit, 1 source
    logic       o_fire, o_grant, o_act;
    logic [7:0] o_dest, o_wdest, o_creg;
    logic [0:0] o_haz;
    logic       o_any;
    logic [7:0] o_pend;

    wr_pending_board #(.NREG(8), .MODE(ADDR_ONEHOT), .NUNIT(1), .NSRC(1)) dut_oh (
        .clk(clk), .rst(rst),
        .iss_fire(o_fire), .iss_sel(o_fire), .iss_wflag(o_fire),
        .iss_dest(o_dest),
        .wr_grant(o_grant), .wr_dest(o_wdest),
        .unit_busy(1'b0), .unit_done(1'b0), .unit_dok(1'b0),
        .chk_act(o_act), .chk_busy(1'b0), .chk_reg(o_creg),
        .chk_hazard(o_haz), .any_hazard(o_any), .pending(o_pend)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] pend;
        logic [1:0]  haz;
        logic        anyh;
        string       tag;
    } exp_t;
    exp_t expq[$];

    // reference state, advanced at each rising edge
    logic [15:0] m_pend = '0;
    logic [1:0]  m_cap  = '0;
    logic [3:0]  m_ldest [2] = '{4'd0, 4'd0};
    logic [1:0]  m_stop = '0;

    function automatic logic [15:0] bit_of(input logic [3:0] r);
        return 16'(1) << r;
    endfunction

    task automatic quiet();
        fire = '0; sel = '0; wflag = '0; grant = '0; done = '0; dok = '0;
    endtask

    // driver: queue expectation for this cycle, advance model, move to next cycle
    task automatic cyc(input string tag);
        exp_t e;
        logic [15:0] setv, clrv;
        logic [3:0] id [2];
        logic [3:0] wd [2];
        logic [3:0] cr [2];
        id[0] = idest0; id[1] = idest1;
        wd[0] = wdest0; wd[1] = wdest1;
        cr[0] = creg0;  cr[1] = creg1;
        e.pend = m_pend;
        for (int s = 0; s < 2; s++)
            e.haz[s] = act[s] && !m_stop[s] && ((m_pend & bit_of(cr[s])) != 0);
        e.anyh = |e.haz;
        e.tag  = tag;
        expq.push_back(e);
        setv = '0; clrv = '0;
        for (int u = 0; u < 2; u++) begin
            if (fire[u] && sel[u] && wflag[u]) setv |= bit_of(id[u]);
            if (grant[u]) clrv |= bit_of(wd[u]);
            if (done[u] && m_cap[u] && !dok[u]) clrv |= bit_of(m_ldest[u]);
        end
        if (rst) begin
            m_pend = '0; m_cap = '0; m_stop = '0;
            m_ldest[0] = '0; m_ldest[1] = '0;
        end else begin
            m_pend = (m_pend & ~clrv) | setv;
            for (int u = 0; u < 2; u++) begin
                if (!busy[u]) m_cap[u] = 1'b0;
                if (fire[u] && sel[u]) begin
                    m_cap[u] = wflag[u];
                    m_ldest[u] = id[u];
                end
            end
            for (int s = 0; s < 2; s++)
                m_stop[s] = cbusy[s] && (m_stop[s] || !e.haz[s]);
        end
        @(negedge clk);
    endtask

    // monitor: compare a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (pend !== e.pend || haz !== e.haz || anyh !== e.anyh) begin
                    errors++;
                    $display("FAIL %s: pending=%h haz=%b any=%b expected pending=%h haz=%b any=%b",
                             e.tag, pend, haz, anyh, e.pend, e.haz, e.anyh);
                end
            end
        end
    end

    task automatic direct(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        quiet();
        busy = '0; act = '0; cbusy = '0;
        idest0 = '0; idest1 = '0; wdest0 = '0; wdest1 = '0; creg0 = '0; creg1 = '0;
        o_fire = 0; o_grant = 0; o_act = 0; o_dest = '0; o_wdest = '0; o_creg = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);

        // R1: issue attempted under reset sets nothing
        fire = 2'b01; sel = 2'b01; wflag = 2'b01; idest0 = 4'd3; busy = 2'b01;
        cyc("R1 reset");
        quiet(); busy = '0; rst = 1'b0;
        cyc("R1 after reset");

        // R2: missing select or write flag sets nothing; all three set bit 5
        fire = 2'b01; sel = 2'b00; wflag = 2'b01; idest0 = 4'd5;
        cyc("R2 no select");
        sel = 2'b01; wflag = 2'b00;
        cyc("R2 no wflag");
        // R11: check of reg 5 in the issue cycle sees nothing yet
        wflag = 2'b01; act = 2'b01; creg0 = 4'd5;
        cyc("R2 R11 issue cycle");
        quiet();
        cyc("R7 R11 hazard next cycle");
        // R6: neighbours of reg 5 are not hazards (binary mask = 1<<n)
        creg0 = 4'd4; act = 2'b11; creg1 = 4'd6;
        cyc("R6 binary neighbours");

        // R9: two units set different bits together
        fire = 2'b11; sel = 2'b11; wflag = 2'b11; idest0 = 4'd2; idest1 = 4'd9;
        creg0 = 4'd2; creg1 = 4'd9;
        cyc("R9 dual set");
        quiet();
        cyc("R9 R7 both hazards");

        // R3: granted write clears bit 9 one cycle later
        grant = 2'b10; wdest1 = 4'd9;
        cyc("R3 write cycle");
        quiet();
        cyc("R3 cleared");

        // R10: set and clear of bit 2 together keeps it set
        fire = 2'b01; sel = 2'b01; wflag = 2'b01; idest0 = 4'd2;
        grant = 2'b10; wdest1 = 4'd2;
        cyc("R10 collision");
        quiet(); act = '0;
        cyc("R10 kept");

        // R4: done without data clears latched dest; done with data does not
        fire = 2'b11; sel = 2'b11; wflag = 2'b11; idest0 = 4'd7; idest1 = 4'd12;
        busy = 2'b11;
        cyc("R4 issue");
        quiet(); idest0 = 4'd0; idest1 = 4'd0;
        cyc("R4 busy");
        done = 2'b11; dok = 2'b10;
        cyc("R4 done");
        quiet(); busy = '0;
        cyc("R4 dropped 7, kept 12");
        grant = 2'b10; wdest1 = 4'd12;
        cyc("R4 write 12");
        quiet();
        cyc("R4 12 cleared");

        // R5: flag reset by idle cycle, later done clears nothing
        fire = 2'b01; sel = 2'b01; wflag = 2'b01; idest0 = 4'd4; busy = 2'b01;
        cyc("R5 issue");
        quiet(); busy = 2'b00;
        cyc("R5 idle");
        busy = 2'b01; done = 2'b01; dok = 2'b00;
        cyc("R5 late done");
        quiet(); busy = '0;
        cyc("R5 bit 4 kept");

        // R8: busy source with no hazard stops checking until busy drops
        act = 2'b10; creg1 = 4'd13; cbusy = 2'b10;
        cyc("R8 busy no hazard");
        fire = 2'b10; sel = 2'b10; wflag = 2'b10; idest1 = 4'd13;
        cyc("R8 writer issues");
        quiet();
        cyc("R8 stopped");
        cyc("R8 still stopped");
        cbusy = 2'b00;
        cyc("R8 busy falls");
        cyc("R8 checking resumed");
        act = '0;
        cyc("R7 inactive source");

        // R6: one-hot addressing uses select directly as mask
        o_fire = 1; o_dest = 8'b0010_0000;
        @(negedge clk);
        o_fire = 0; o_act = 1; o_creg = 8'b0000_0001;
        #(CLK_PERIOD/4);
        direct("R6 onehot pending", {8'h00, o_pend}, 16'h0020);
        direct("R6 onehot no match", {15'd0, o_haz}, 16'h0000);
        o_creg = 8'b0010_0001;
        #1;
        direct("R6 onehot multi-bit match", {15'd0, o_haz}, 16'h0001);
        @(negedge clk);
        o_grant = 1; o_wdest = 8'b0010_0000;
        @(negedge clk);
        o_grant = 0;
        #(CLK_PERIOD/4);
        direct("R3 onehot cleared", {8'h00, o_pend}, 16'h0000);

        @(negedge clk);
        #(CLK_PERIOD/2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule